// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Bank with Atomic Set and Clear

This block gives a processor register access to a bank of 8-bit general-purpose I/O ports. One 32-bit word per port carries everything software normally needs: the pin directions, the driven output levels, the pin levels seen when reset was last released, and the live pin levels. Two write-only registers next to that word let software raise or lower chosen output bits without a read-modify-write. This keeps updates to pins shared by different pieces of code safe.

Each port drives an output value and an output enable per pin toward its pads, and it takes one input level per pad. The pad levels pass through a two-flop synchronizer before anything reads them. On the first clock after reset is released, each port stores its synchronized pad levels as a read-only snapshot. That snapshot is kept until the next reset. The bus is a plain single-cycle interface. Writes happen on the clock edge when `wr_en` is high. Reads are combinational, and `rd_data` is valid while `rd_en` is high.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit and output bit is 0, so `pad_oe` and `pad_out` are all 0.
- R2: Port p has its data word at address p*0x10. In that word, bits 31:24 are the direction (1 = output) and bits 23:16 are the output levels. A write updates both fields. `pad_oe` follows the direction bits and `pad_out` follows the output bits. Port p maps to pins p*8 through p*8+7.
- R3: The direction bits change only on a write to the port's data word. Set and clear writes leave them unchanged.
- R4: A write to address p*0x10+0x4 raises every output bit whose matching bit in wr_data[23:16] is 1. All other output bits are left unchanged.
- R5: A write to address p*0x10+0x8 lowers every output bit whose matching bit in wr_data[23:16] is 1. All other output bits are left unchanged.
- R6: In set and clear writes, bits 31:24 and 15:0 are ignored. In data word writes, bits 15:0 are ignored.
- R7: Data word bits 15:8 hold the synchronized pad levels from the first clock after reset is released. They stay fixed until the next reset.
- R8: Data word bits 7:0 show the pad levels two clock edges after the pads change, and not one edge after.
- R9: Reads return 0 for the set and clear addresses, for offset 0xC, for port slots at index 5 and above, and whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (8) | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4*PORT_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 4*PORT_W (32) | Read data, combinational, 0 when no register is selected |
| pad_in | input | NUM_PORTS*PORT_W (40) | Pad input levels, asynchronous |
| pad_out | output | NUM_PORTS*PORT_W (40) | Pad output levels |
| pad_oe | output | NUM_PORTS*PORT_W (40) | Pad output enables |

## Verification
The bench uses the default parameters: five ports of eight pins and an 8-bit address. With a 4-bit port index, slots 5 to 15 exist in the address space but have no port behind them, so reads of unmapped slots can be tested directly. Eight-bit ports fill the 32-bit word exactly, so every field boundary can be checked. The bench applies reset twice with different pad patterns to show that the snapshot reloads. It also releases reset on the same edge where the pads change, so the snapshot has to keep the pre-release levels.

// File: rtl/gpio_pkg.sv
// Package: gpio_pkg
// Shared register offsets for the GPIO bank. It assumes a 16-byte slot per
// port, with the register offset held in the low four address bits.
package gpio_pkg;
    localparam int SLOT_BITS = 4;
    localparam logic [SLOT_BITS-1:0] OFF_DATA = 4'h0;
    localparam logic [SLOT_BITS-1:0] OFF_SET  = 4'h4;
    localparam logic [SLOT_BITS-1:0] OFF_CLR  = 4'h8;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Two-flop synchronizer for asynchronous pad levels. It assumes nothing about
// the input timing. The flops have no reset, so they keep sampling while
// reset is held, which lets the reset snapshot see the real pad levels.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift the pad levels through two stages.
    always_ff @(posedge clk) begin
        meta_q <= d;
        q      <= meta_q;
    end
endmodule

// File: rtl/gpio_decode.sv
// Module: gpio_decode
// Decodes a byte address into one-hot selects for the data, set and clear
// registers of each port. It assumes a port index in the address bits above
// the slot offset. Slots with no port and unused offsets select nothing.
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_PORTS-1:0] sel_data,
    output logic [NUM_PORTS-1:0] sel_set,
    output logic [NUM_PORTS-1:0] sel_clr
);
    localparam int IDX_W = ADDR_W - SLOT_BITS;

    logic [IDX_W-1:0]     idx;
    logic [SLOT_BITS-1:0] off;

    assign idx = addr[ADDR_W-1:SLOT_BITS];
    assign off = addr[SLOT_BITS-1:0];

    // Match the port index and the slot offset.
    always_comb begin
        sel_data = '0;
        sel_set  = '0;
        sel_clr  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (idx == IDX_W'(p)) begin
                sel_data[p] = (off == OFF_DATA);
                sel_set[p]  = (off == OFF_SET);
                sel_clr[p]  = (off == OFF_CLR);
            end
        end
    end

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_data, sel_set, sel_clr}));
endmodule

// File: rtl/gpio_port.sv
// Module: gpio_port
// One GPIO port. It holds the direction and output registers, the reset
// snapshot, and the synchronizer, and it builds the 32-bit read word.
// It assumes that at most one of the write strobes is high in any cycle.
module gpio_port #(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_data_en,
    input  logic                wr_set_en,
    input  logic                wr_clr_en,
    input  logic [4*PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0]   pad_in,
    output logic [PORT_W-1:0]   pad_out,
    output logic [PORT_W-1:0]   pad_oe,
    output logic [4*PORT_W-1:0] word
);
    localparam int DIR_LSB = 3 * PORT_W;
    localparam int OUT_LSB = 2 * PORT_W;

    logic [PORT_W-1:0] dir_q, out_q, snap_q, live;
    logic              snap_done_q;
    logic [PORT_W-1:0] wr_mask;

    assign wr_mask = wdata[OUT_LSB +: PORT_W];

    gpio_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (live)
    );

    // Direction register: loaded only by a data word write.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_q <= '0;
        else if (wr_data_en) dir_q <= wdata[DIR_LSB +: PORT_W];
    end

    // Output register: a full load, a bitwise set or a bitwise clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          out_q <= '0;
        else if (wr_data_en) out_q <= wr_mask;
        else if (wr_set_en)  out_q <= out_q | wr_mask;
        else if (wr_clr_en)  out_q <= out_q & ~wr_mask;
    end

    // Snapshot: take the synchronized pads once after reset, then hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q      <= '0;
            snap_done_q <= 1'b0;
        end else if (!snap_done_q) begin
            snap_q      <= live;
            snap_done_q <= 1'b1;
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = out_q;
    assign word    = {dir_q, out_q, snap_q, live};

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data_en |=> $stable(pad_oe));
    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set_en |=> ((pad_out & $past(wr_mask)) == $past(wr_mask))
                      && ((pad_out & ~$past(wr_mask)) == ($past(pad_out) & ~$past(wr_mask))));
    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_en |=> ((pad_out & $past(wr_mask)) == '0)
                      && ((pad_out & ~$past(wr_mask)) == ($past(pad_out) & ~$past(wr_mask))));
    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_done_q |=> $stable(snap_q));
endmodule

// File: rtl/gpio_bank.sv
// Module: gpio_bank
// Top of the GPIO bank. It decodes the register bus, steers the write
// strobes to each port, and multiplexes the read word. It assumes a
// single-cycle bus with reads that are combinational.
module gpio_bank #(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [4*PORT_W-1:0]         wr_data,
    input  logic                        rd_en,
    output logic [4*PORT_W-1:0]         rd_data,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe
);
    localparam int WORD_W = 4 * PORT_W;

    logic [NUM_PORTS-1:0] sel_data, sel_set, sel_clr;
    logic [WORD_W-1:0]    port_word [NUM_PORTS];

    gpio_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .sel_data (sel_data),
        .sel_set  (sel_set),
        .sel_clr  (sel_clr)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port #(.PORT_W(PORT_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_data_en (wr_en & sel_data[p]),
            .wr_set_en  (wr_en & sel_set[p]),
            .wr_clr_en  (wr_en & sel_clr[p]),
            .wdata      (wr_data),
            .pad_in     (pad_in[p*PORT_W +: PORT_W]),
            .pad_out    (pad_out[p*PORT_W +: PORT_W]),
            .pad_oe     (pad_oe[p*PORT_W +: PORT_W]),
            .word       (port_word[p])
        );
    end

    // Read mux: only a selected data word returns a value.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_en && sel_data[p]) rd_data = port_word[p];
        end
    end

    // R9
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (|sel_set || |sel_clr)) |-> (rd_data == '0));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int NP = 5;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [NP*PW-1:0] pad_in = '0;
    logic [NP*PW-1:0] pad_out, pad_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_dir [NP];
    logic [7:0] exp_out [NP];
    logic [7:0] exp_snap [NP];

    always #5 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    // Reset with a given pad pattern, releasing on the edge the pads change.
    task automatic do_reset(input logic [NP*PW-1:0] pre, input logic [NP*PW-1:0] post);
        @(negedge clk);
        rst_n = 1'b0; pad_in = pre;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; pad_in = post;
        for (int p = 0; p < NP; p++) begin
            exp_dir[p] = '0; exp_out[p] = '0; exp_snap[p] = pre[p*PW +: PW];
        end
        @(negedge clk);
    endtask

    task automatic check_port(input string req, input int p);
        logic [31:0] d;
        bus_read(8'(p * 16), d);
        check(req, d[31:16], {exp_dir[p], exp_out[p]});
        check(req, pad_oe[p*PW +: PW], exp_dir[p]);
        check(req, pad_out[p*PW +: PW], exp_out[p]);
    endtask

    task automatic t_reset_state();
        check("R1 oe", pad_oe, '0);
        check("R1 out", pad_out, '0);
        for (int p = 0; p < NP; p++) check_port("R1", p);
    endtask

    task automatic t_data_rw();
        for (int p = 0; p < NP; p++) begin
            logic [7:0] dv = 8'hA5 ^ 8'(p * 37);
            logic [7:0] ov = 8'h3C + 8'(p);
            bus_write(8'(p * 16), {dv, ov, 16'hFFFF});
            exp_dir[p] = dv; exp_out[p] = ov;
        end
        for (int p = 0; p < NP; p++) check_port("R2", p);
    endtask

    task automatic t_set_clr();
        bus_write(8'h14, 32'h0081_0000);
        exp_out[1] = exp_out[1] | 8'h81;
        check_port("R4", 1);
        bus_write(8'h14, 32'h0000_0000);
        check_port("R4 zero mask", 1);
        bus_write(8'h28, 32'h00F0_0000);
        exp_out[2] = exp_out[2] & 8'h0F;
        check_port("R5", 2);
        bus_write(8'h48, 32'h00FF_0000);
        exp_out[4] = 8'h00;
        check_port("R5 all", 4);
        bus_write(8'h44, 32'h00FF_0000);
        exp_out[4] = 8'hFF;
        check_port("R4 all", 4);
        for (int p = 0; p < NP; p++) check_port("R3", p);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_write(8'h34, 32'hFF00_FFFF);
        check_port("R6 set", 3);
        bus_write(8'h38, 32'hFF00_FFFF);
        check_port("R6 clr", 3);
        bus_write(8'h00, {exp_dir[0], exp_out[0], 16'h5AA5});
        bus_read(8'h00, d);
        check("R6 ro", d[15:8], exp_snap[0]);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        @(negedge clk);
        pad_in[2*PW +: PW] = 8'hC3;
        pad_in[0 +: PW] = 8'h18;
        @(negedge clk);
        bus_read(8'h20, d);
        check("R8 one edge", d[7:0] == 8'hC3, 1'b0);
        @(negedge clk);
        bus_read(8'h20, d);
        check("R8 port2", d[7:0], 8'hC3);
        bus_read(8'h00, d);
        check("R8 port0", d[7:0], 8'h18);
        check("R7 held", d[15:8], exp_snap[0]);
    endtask

    task automatic t_snapshot(input logic [NP*PW-1:0] pre, input logic [NP*PW-1:0] post);
        logic [31:0] d;
        do_reset(pre, post);
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            bus_read(8'(p * 16), d);
            check("R7 snap", d[15:8], exp_snap[p]);
            check("R7 live", d[7:0], post[p*PW +: PW]);
        end
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h10, 32'hFFFF_0000);
        exp_dir[1] = 8'hFF; exp_out[1] = 8'hFF;
        bus_read(8'h14, d); check("R9 set rd", d, 32'h0);
        bus_read(8'h18, d); check("R9 clr rd", d, 32'h0);
        bus_read(8'h1C, d); check("R9 off C", d, 32'h0);
        bus_read(8'h50, d); check("R9 slot5", d, 32'h0);
        bus_read(8'hF0, d); check("R9 slot15", d, 32'h0);
        bus_write(8'h50, 32'h0000_0000);
        bus_write(8'h1C, 32'h0000_0000);
        check_port("R9 stray write", 1);
        addr = 8'h10; rd_en = 1'b0;
        #1 check("R9 no rd_en", rd_data, 32'h0);
    endtask

    initial begin
        do_reset(40'h1122334455, 40'h1122334455);
        t_reset_state();
        t_data_rw();
        t_set_clr();
        t_reserved();
        t_sync();
        t_snapshot(40'hDEADBEEF01, 40'h0123456789);
        t_reset_state();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule